// File: doc/BRIEF.md
# Decrement Instruction Decoder

This block takes the bytes of one instruction from a byte stream and states whether the instruction is a decrement. If it is, the block reports the operand width, whether the destination is a register or memory, and the register number. A mode input selects 64-bit decoding or legacy/compatibility decoding. The two modes differ mainly in how the bytes 48h–4Fh are read. In legacy mode they are a one-byte register decrement. In 64-bit mode they are an extension prefix. That prefix can widen the operand to 64 bits and can reach registers 8 to 15.

Bytes arrive on a valid/ready input, one per accepted cycle. The producer sends the prefixes, the opcode, and the ModRM byte when the opcode needs one. It sends nothing past that point. Any displacement or SIB bytes are not part of this stream. The decoder accepts a byte on each rising edge where `in_valid` and `in_ready` are both high. When the last byte needed is accepted, a result appears on the output side with `res_valid` high in the next cycle. It stays there, unchanged, until `res_ready` is seen high. While a result is waiting, `in_ready` is low, so back-pressure on the result side stalls the byte stream. `mode64` must be held constant from the first byte of an instruction until its result is accepted.

Top module: `decr_decode`

## Requirements
- R1: Opcode FEh followed by a ModRM byte whose bits 5:3 equal 1 is recognised (`res_hit`=1) with `res_size`=0. The size code is 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit.
- R2: Opcode FFh with ModRM bits 5:3 equal 1 is recognised. Its size is 32 by default and 16 after a 66h prefix. It is 64 when an honoured extension prefix has bit 3 set, and that wins over 66h.
- R3: In legacy mode a byte 48h–4Fh in opcode position is a recognised register decrement. Its register number is bits 2:0 of the byte, and its size is 32, or 16 after 66h.
- R4: In 64-bit mode, bytes 40h–4Fh are extension prefixes and never decrement opcodes. An honoured prefix's bit 0 becomes bit 3 of the register number of a register destination.
- R5: An extension prefix is honoured only when it is the byte directly before the opcode. If a 66h or F0h byte follows it, its effect is dropped.
- R6: For an 8-bit register destination with ModRM bits 2:0 in 4–7, behaviour depends on the extension prefix. Without an honoured prefix, `res_hib`=1 and `res_reg` is the value minus 4 (the high byte of registers 0–3). With any honoured prefix, even 40h, `res_hib`=0 and `res_reg` is the full number.
- R7: An F0h prefix on a recognised decrement with a register destination sets `res_ud`=1. With a memory destination, `res_ud` stays 0.
- R8: ModRM bits 7:6 equal to 3 mean a register destination (`res_mem`=0). Any other value means memory (`res_mem`=1), and then `res_reg`=0.
- R9: An unrecognised instruction gives `res_hit`=0 with every other result field 0, including `res_ud`. This covers FEh/FFh with ModRM bits 5:3 not equal to 1, any other opcode, and legacy 40h–47h.
- R10: While `res_valid` is high, `in_ready` is low. The result fields hold steady until the cycle after `res_ready` is seen high.
- R11: Reset clears `res_valid`, raises `in_ready`, and discards all prefixes collected so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode64 | input | 1 | 1 = 64-bit decoding, 0 = legacy/compatibility |
| in_valid | input | 1 | A byte is offered on `in_byte` |
| in_ready | output | 1 | Decoder can take a byte this cycle |
| in_byte | input | 8 | Instruction byte |
| res_valid | output | 1 | Decode result is present |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_hit | output | 1 | Instruction is a decrement |
| res_ud | output | 1 | Invalid-opcode condition |
| res_mem | output | 1 | Destination is memory |
| res_hib | output | 1 | Destination is the high byte of register `res_reg` |
| res_size | output | 2 | Operand size code (0 = 8, 1 = 16, 2 = 32, 3 = 64) |
| res_reg | output | 4 | Destination register number (0 for memory) |

## Verification
The bench targets three corner cases.

1. **Bytes 48h–4Fh across the two modes.** A decoder that ignored `mode64` would report a one-byte decrement in 64-bit mode, or would treat legacy 4Bh as a prefix and then hang waiting for an opcode.
2. **How long a prefix stays in force.** A prefix placed before 66h must lose its effect; a design that kept it would report 64-bit size or an extended register where 16-bit or a low register is due. A bare 40h must still stop high-byte selection. Collected prefixes must not survive a mid-instruction reset; if they did, the next instruction would show a stale 16-bit size or a false invalid flag.
3. **The lock rule and the stall rule.** The lock rule is tested on register destinations, on memory destinations and on a non-decrement ModRM group. A result that moved, or a byte accepted while the result output was stalled, would show up as a changed field or a lost instruction in the scoreboard.

// File: rtl/decr_pkg.sv
package decr_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 4;
  localparam int SZ_W   = 2;

  localparam logic [BYTE_W-1:0] PFX_OSZ  = 8'h66;
  localparam logic [BYTE_W-1:0] PFX_LOCK = 8'hF0;
  localparam logic [BYTE_W-1:0] OPC_B    = 8'hFE;
  localparam logic [BYTE_W-1:0] OPC_V    = 8'hFF;
  localparam logic [3:0]        EXT_HI   = 4'h4;
  localparam logic [4:0]        SHORT_HI = 5'b01001;
  localparam logic [2:0]        SUB_DEC  = 3'd1;
  localparam logic [1:0]        MOD_REG  = 2'b11;

  typedef enum logic [SZ_W-1:0] {
    SZ8  = 2'd0,
    SZ16 = 2'd1,
    SZ32 = 2'd2,
    SZ64 = 2'd3
  } opsz_e;

  typedef struct packed {
    logic             hit;
    logic             ud;
    logic             mem;
    logic             hib;
    opsz_e            size;
    logic [REG_W-1:0] rnum;
  } dec_res_t;

  typedef enum logic [1:0] {
    ST_PFX   = 2'd0,
    ST_MODRM = 2'd1,
    ST_HOLD  = 2'd2
  } dec_st_e;
endpackage

// File: rtl/decr_pfx_track.sv
module decr_pfx_track
  import decr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic              mode64,
  input  logic [BYTE_W-1:0] cur_byte,
  output logic              is_pfx,
  output logic              osz,
  output logic              lock,
  output logic              ext_on,
  output logic              ext_w,
  output logic              ext_b
);
  logic hit_osz, hit_lock, hit_ext;

  always_comb begin
    hit_osz  = (cur_byte == PFX_OSZ);
    hit_lock = (cur_byte == PFX_LOCK);
    hit_ext  = mode64 && (cur_byte[BYTE_W-1:4] == EXT_HI);
    is_pfx   = hit_osz || hit_lock || hit_ext;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      osz    <= 1'b0;
      lock   <= 1'b0;
      ext_on <= 1'b0;
      ext_w  <= 1'b0;
      ext_b  <= 1'b0;
    end else if (take && is_pfx) begin
      if (hit_osz)  osz  <= 1'b1;
      if (hit_lock) lock <= 1'b1;
      if (hit_ext) begin
        ext_on <= 1'b1;
        ext_w  <= cur_byte[3];
        ext_b  <= cur_byte[0];
      end else begin
        ext_on <= 1'b0;
        ext_w  <= 1'b0;
        ext_b  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/decr_field_form.sv
module decr_field_form
  import decr_pkg::*;
(
  input  logic              use_modrm,
  input  logic              op8,
  input  logic              mode64,
  input  logic [BYTE_W-1:0] cur_byte,
  input  logic              osz,
  input  logic              lock,
  input  logic              ext_on,
  input  logic              ext_w,
  input  logic              ext_b,
  output dec_res_t          res
);
  opsz_e wide_sz;

  always_comb begin
    if (ext_on && ext_w) wide_sz = SZ64;
    else if (osz)        wide_sz = SZ16;
    else                 wide_sz = SZ32;
  end

  always_comb begin
    res = '0;
    if (use_modrm) begin
      if (cur_byte[5:3] == SUB_DEC) begin
        res.hit  = 1'b1;
        res.mem  = (cur_byte[7:6] != MOD_REG);
        res.size = op8 ? SZ8 : wide_sz;
        res.ud   = lock && !res.mem;
        if (!res.mem) begin
          if (op8 && !ext_on && cur_byte[2]) begin
            res.hib  = 1'b1;
            res.rnum = {2'b00, cur_byte[1:0]};
          end else begin
            res.rnum = {ext_b, cur_byte[2:0]};
          end
        end
      end
    end else if (!mode64 && cur_byte[BYTE_W-1:3] == SHORT_HI) begin
      res.hit  = 1'b1;
      res.size = osz ? SZ16 : SZ32;
      res.rnum = {1'b0, cur_byte[2:0]};
      res.ud   = lock;
    end
  end
endmodule

// File: rtl/decr_out_reg.sv
module decr_out_reg
  import decr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  dec_res_t din,
  input  logic     ready,
  output logic     valid,
  output dec_res_t dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load && !valid) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/decr_decode.sv
module decr_decode
  import decr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode64,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  output logic              res_ud,
  output logic              res_mem,
  output logic              res_hib,
  output logic [SZ_W-1:0]   res_size,
  output logic [REG_W-1:0]  res_reg
);
  dec_st_e  st;
  logic     op8_q;
  logic     take, is_pfx, is_grp, load, done;
  logic     osz, lock, ext_on, ext_w, ext_b;
  dec_res_t formed, held;

  assign in_ready = (st != ST_HOLD);
  assign take     = in_valid && in_ready;
  assign is_grp   = (in_byte == OPC_B) || (in_byte == OPC_V);
  assign done     = res_valid && res_ready;
  assign load     = take && ((st == ST_MODRM) || (st == ST_PFX && !is_pfx && !is_grp));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_PFX;
      op8_q <= 1'b0;
    end else begin
      case (st)
        ST_PFX: if (take && !is_pfx) begin
          if (is_grp) begin
            st    <= ST_MODRM;
            op8_q <= (in_byte == OPC_B);
          end else begin
            st <= ST_HOLD;
          end
        end
        ST_MODRM: if (take) st <= ST_HOLD;
        ST_HOLD:  if (done) st <= ST_PFX;
        default:  st <= ST_PFX;
      endcase
    end
  end

  decr_pfx_track u_pfx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (done),
    .take     (take && st == ST_PFX),
    .mode64   (mode64),
    .cur_byte (in_byte),
    .is_pfx   (is_pfx),
    .osz      (osz),
    .lock     (lock),
    .ext_on   (ext_on),
    .ext_w    (ext_w),
    .ext_b    (ext_b)
  );

  decr_field_form u_form (
    .use_modrm (st == ST_MODRM),
    .op8       (op8_q),
    .mode64    (mode64),
    .cur_byte  (in_byte),
    .osz       (osz),
    .lock      (lock),
    .ext_on    (ext_on),
    .ext_w     (ext_w),
    .ext_b     (ext_b),
    .res       (formed)
  );

  decr_out_reg u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .din   (formed),
    .ready (res_ready),
    .valid (res_valid),
    .dout  (held)
  );

  assign res_hit  = held.hit;
  assign res_ud   = held.ud;
  assign res_mem  = held.mem;
  assign res_hib  = held.hib;
  assign res_size = held.size;
  assign res_reg  = held.rnum;
endmodule

// File: rtl/decr_decode_chk.sv
module decr_decode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       res_valid,
  input logic       res_ready,
  input logic       res_hit,
  input logic       res_ud,
  input logic       res_mem,
  input logic       res_hib,
  input logic [1:0] res_size,
  input logic [3:0] res_reg
);
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid &&
      $stable({res_hit, res_ud, res_mem, res_hib, res_size, res_reg}));

  a_r10_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !in_ready);

  a_r7_ud_on_reg: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ud |-> res_hit && !res_mem);

  a_r6_hib_shape: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_hib |-> res_size == 2'd0 && !res_mem && res_reg[3:2] == 2'b00);

  a_r9_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> !res_ud && !res_mem && !res_hib && res_size == 2'd0 && res_reg == 4'd0);

  a_r8_mem_reg0: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_mem |-> res_reg == 4'd0 && !res_hib);
endmodule

bind decr_decode decr_decode_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_hit   (res_hit),
  .res_ud    (res_ud),
  .res_mem   (res_mem),
  .res_hib   (res_hib),
  .res_size  (res_size),
  .res_reg   (res_reg)
);

// File: tb/decr_decode_tb.sv
`timescale 1ns/1ps
module decr_decode_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode64 = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_byte = 8'h00;
  logic       res_valid;
  logic       res_ready = 1'b0;
  logic       res_hit, res_ud, res_mem, res_hib;
  logic [1:0] res_size;
  logic [3:0] res_reg;

  int checks = 0;
  int errors = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];
  logic       stall_prev = 1'b0;
  logic [9:0] held_prev = '0;
  logic [4:0] lfsr = 5'h13;

  always #2.5 clk = ~clk;

  decr_decode u_dut (
    .clk(clk), .rst_n(rst_n), .mode64(mode64),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_hit(res_hit), .res_ud(res_ud), .res_mem(res_mem), .res_hib(res_hib),
    .res_size(res_size), .res_reg(res_reg)
  );

  function automatic logic [9:0] mk(input logic hit, input logic ud, input logic mem,
                                    input logic hib, input logic [1:0] sz, input logic [3:0] rg);
    return {hit, ud, mem, hib, sz, rg};
  endfunction

  task automatic finish_sim();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // result-side back-pressure pattern
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[3:0], lfsr[4] ^ lfsr[2]};
    res_ready <= lfsr[0] | lfsr[3];
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    logic [9:0] act;
    act = {res_hit, res_ud, res_mem, res_hib, res_size, res_reg};
    if (!rst_n) begin
      stall_prev = 1'b0;
    end else begin
      if (stall_prev) begin
        checks++;
        if (!res_valid || act != held_prev) begin
          errors++;
          $display("FAIL R10 held result moved: act=%h exp=%h", act, held_prev);
        end
      end
      if (res_valid) begin
        checks++;
        if (in_ready) begin
          errors++;
          $display("FAIL R10 in_ready with pending result: act=1 exp=0");
        end
      end
      if (res_valid && res_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL unexpected result: act=%h exp=none", act);
        end else begin
          logic [9:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (act !== e) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", t, act, e);
          end
        end
      end
      stall_prev = res_valid && !res_ready;
      held_prev  = act;
    end
  end

  task automatic push_byte(input logic [7:0] b);
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_instr(input logic m, input int n,
                            input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                            input logic [7:0] b3, input logic [7:0] b4,
                            input logic [9:0] e, input string t);
    logic [7:0] bs [5];
    bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3; bs[4] = b4;
    // wait until the previous result has left before switching mode
    while (exp_q.size() != 0) @(negedge clk);
    mode64 = m;
    exp_q.push_back(e);
    tag_q.push_back(t);
    for (int i = 0; i < n; i++) push_byte(bs[i]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: act=running exp=finished");
    finish_sim();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R11 reset state: act=%b%b exp=01", res_valid, in_ready);
    end
    @(posedge clk); #1 rst_n = 1'b1;

    send_instr(0, 2, 8'hFE, 8'hC9, 0, 0, 0, mk(1,0,0,0,2'd0,4'd1),  "R1 FE /1 reg1");
    send_instr(0, 2, 8'hFE, 8'hCD, 0, 0, 0, mk(1,0,0,1,2'd0,4'd1),  "R6 high byte no prefix");
    send_instr(1, 3, 8'h40, 8'hFE, 8'hCD, 0, 0, mk(1,0,0,0,2'd0,4'd5), "R6 bare 40h blocks high byte");
    send_instr(1, 3, 8'h41, 8'hFE, 8'hCD, 0, 0, mk(1,0,0,0,2'd0,4'd13), "R4 ext B on 8-bit");
    send_instr(0, 2, 8'hFF, 8'hC8, 0, 0, 0, mk(1,0,0,0,2'd2,4'd0),  "R2 default 32");
    send_instr(0, 3, 8'h66, 8'hFF, 8'hC8, 0, 0, mk(1,0,0,0,2'd1,4'd0), "R2 66h gives 16");
    send_instr(1, 3, 8'h48, 8'hFF, 8'hC8, 0, 0, mk(1,0,0,0,2'd3,4'd0), "R2 W gives 64");
    send_instr(1, 4, 8'h66, 8'h48, 8'hFF, 8'hCB, 0, mk(1,0,0,0,2'd3,4'd3), "R2 W over 66h");
    send_instr(1, 3, 8'h49, 8'hFF, 8'hCF, 0, 0, mk(1,0,0,0,2'd3,4'd15), "R4 reg15");
    send_instr(1, 2, 8'hFF, 8'hC8, 0, 0, 0, mk(1,0,0,0,2'd2,4'd0),  "R2 64-bit default 32");
    send_instr(1, 3, 8'h4C, 8'hFF, 8'hC8, 0, 0, mk(1,0,0,0,2'd3,4'd0), "R2 4Ch W set");
    send_instr(0, 1, 8'h4B, 0, 0, 0, 0, mk(1,0,0,0,2'd2,4'd3),      "R3 short 4Bh");
    send_instr(0, 2, 8'h66, 8'h4F, 0, 0, 0, mk(1,0,0,0,2'd1,4'd7),  "R3 short 16-bit");
    send_instr(1, 2, 8'h4A, 8'h90, 0, 0, 0, mk(0,0,0,0,2'd0,4'd0),  "R4 4Ah is prefix in 64-bit");
    send_instr(1, 4, 8'h48, 8'h66, 8'hFF, 8'hC8, 0, mk(1,0,0,0,2'd1,4'd0), "R5 stale W dropped");
    send_instr(1, 4, 8'h41, 8'h66, 8'hFE, 8'hCD, 0, mk(1,0,0,1,2'd0,4'd1), "R5 stale ext dropped");
    send_instr(0, 3, 8'hF0, 8'hFF, 8'hC8, 0, 0, mk(1,1,0,0,2'd2,4'd0), "R7 lock on register");
    send_instr(0, 3, 8'hF0, 8'hFF, 8'h08, 0, 0, mk(1,0,1,0,2'd2,4'd0), "R7 lock on memory");
    send_instr(0, 2, 8'hFF, 8'h4F, 0, 0, 0, mk(1,0,1,0,2'd2,4'd0),  "R8 mod1 memory");
    send_instr(1, 4, 8'hF0, 8'h41, 8'hFE, 8'hCB, 0, mk(1,1,0,0,2'd0,4'd11), "R7 lock 8-bit reg11");
    send_instr(0, 2, 8'hF0, 8'h4A, 0, 0, 0, mk(1,1,0,0,2'd2,4'd2),  "R7 lock on short form");
    send_instr(0, 2, 8'hFE, 8'hC1, 0, 0, 0, mk(0,0,0,0,2'd0,4'd0),  "R9 FE /0");
    send_instr(0, 3, 8'hF0, 8'hFF, 8'hD0, 0, 0, mk(0,0,0,0,2'd0,4'd0), "R9 lock FF /2");
    send_instr(0, 1, 8'h90, 0, 0, 0, 0, mk(0,0,0,0,2'd0,4'd0),      "R9 other opcode");
    send_instr(0, 1, 8'h43, 0, 0, 0, 0, mk(0,0,0,0,2'd0,4'd0),      "R9 legacy 43h");

    // R11: reset in the middle of a prefix run discards the prefixes
    while (exp_q.size() != 0) @(negedge clk);
    mode64 = 1'b0;
    push_byte(8'h66);
    push_byte(8'hF0);
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    send_instr(0, 2, 8'hFF, 8'hC8, 0, 0, 0, mk(1,0,0,0,2'd2,4'd0), "R11 prefixes cleared by reset");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (5) @(posedge clk);
    finish_sim();
  end
endmodule